// File: doc/BRIEF.md
# Glitch-free prescaled PWM generator

This block produces one pulse-width-modulated output line. A divider built from `DIV` bits slows the clock down. Each time the divider completes its count it issues a one-cycle tick, and the tick advances a free-running period counter that is `WIDTH` bits wide. The output is high for as long as the active duty register is greater than the period counter. One full period therefore lasts 2^WIDTH × 2^DIV clocks, and the output is high for the first duty × 2^DIV clocks of it.

A new duty value is presented on `duty_val` and taken in with a one-cycle `duty_load` strobe. The value goes into a shadow register first. It is copied into the active register only at the moment the period counter rolls over, so a period that has already started always keeps its pulse width. The block is meant to drive an LED brightness or a similar slow analogue load from a clock in the tens of MHz.

Top module: `pwm_glitchfree`

## Requirements
- R1: The period counter advances by one once every 2^DIV clocks. On the tick that finds it at 2^WIDTH-1 it rolls over to 0. One period is therefore 2^WIDTH × 2^DIV clocks long.
- R2: `pwm_out` is 1 exactly when the active duty is strictly greater than the period counter. Within each period the high time comes first, is one unbroken run, and lasts active duty × 2^DIV clocks.
- R3: `duty_val` is written into the shadow register only in cycles where `duty_load` is 1. In any cycle where `duty_load` is 0, the value on `duty_val` has no effect.
- R4: If `duty_load` stays high for several cycles, each cycle's value replaces the previous one. The value present in the last such cycle before the rollover is the one that gets applied.
- R5: The active duty changes only at a counter rollover. A value loaded partway through a period first affects the output in the next period.
- R6: If `duty_load` is high in the same cycle as the rollover tick, the value presented in that cycle becomes the active duty for the period that starts there.
- R7: A duty of 0 keeps `pwm_out` low for the whole period. A duty of 2^WIDTH-1 keeps it high for every count except the last one, which is 2^WIDTH-1 counts out of 2^WIDTH.
- R8: A synchronous active-high `rst` clears the divider, the period counter, the shadow register and the active register. `pwm_out` is low from the first clock after `rst` and stays low until a loaded value has passed through a rollover.
- R9: The divider's tick is never high for two clocks in a row when DIV is greater than 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_val | input | WIDTH | Duty value offered for the next period |
| duty_load | input | 1 | Strobe that writes `duty_val` into the shadow register |
| pwm_out | output | 1 | Modulated output |

## Verification
The embedded properties assume that `duty_load` and `duty_val` are synchronous to `clk` and settle before each rising edge. They also assume that `rst` is held for at least one full clock. The bench meets these conditions by changing every input on the falling edge and by holding reset for several cycles. The bench starts each measured period at a known rollover: either a reset release, or the end of the previous period, which is exactly 2^WIDTH × 2^DIV clocks later. Load strobes can therefore be placed at chosen positions within a period, including the very cycle of the rollover tick.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int unsigned PWM_WIDTH_DEFAULT = 8;
    localparam int unsigned PWM_DIV_DEFAULT   = 11;

    // Number of clocks in one full output period.
    function automatic longint unsigned period_clocks(input int unsigned w, input int unsigned d);
        return longint'(1) << (w + d);
    endfunction

    // Sources the active register can be loaded from at a rollover.
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_SHADOW = 2'd1,
        SRC_DIRECT = 2'd2
    } load_src_e;

    // Decide how the active register is updated.
    function automatic load_src_e pick_source(input logic rollover, input logic load_now);
        if (!rollover)
            return SRC_HOLD;
        else if (load_now)
            return SRC_DIRECT;
        else
            return SRC_SHADOW;
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int unsigned DIV = pwm_pkg::PWM_DIV_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    generate
        if (DIV == 0) begin : g_nodiv
            // No divider: the counter advances on every clock.
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam logic [DIV-1:0] DIV_LAST = '1;
            logic [DIV-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst)
                    div_q <= '0;
                else
                    div_q <= div_q + DIV'(1);
            end

            assign tick_o = (div_q == DIV_LAST);

            // R9: the tick lasts a single cycle.
            assert_tick_single_R9: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int unsigned WIDTH = pwm_pkg::PWM_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             rollover_o
);

    localparam logic [WIDTH-1:0] CNT_LAST = '1;

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + WIDTH'(1);
    end

    assign cnt_o      = cnt_q;
    assign rollover_o = tick_i && (cnt_q == CNT_LAST);

    // R1: the counter only moves on a tick, and then by exactly one.
    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (cnt_q == $past(cnt_q) + WIDTH'(1)));

endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
    parameter int unsigned WIDTH = pwm_pkg::PWM_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] val_i,
    input  logic             rollover_i,
    output logic [WIDTH-1:0] active_o
);

    import pwm_pkg::*;

    logic [WIDTH-1:0] shadow_q;
    logic [WIDTH-1:0] active_q;
    logic [WIDTH-1:0] active_d;
    load_src_e        src;

    assign src = pick_source(rollover_i, load_i);

    always_comb begin
        unique case (src)
            SRC_DIRECT: active_d = val_i;
            SRC_SHADOW: active_d = shadow_q;
            default:    active_d = active_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (load_i)
                shadow_q <= val_i;
            active_q <= active_d;
        end
    end

    assign active_o = active_q;

    // R3: without a load strobe the shadow register keeps its value.
    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(shadow_q));
    // R5: the active duty only moves at a rollover.
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rollover_i |=> $stable(active_q));
    // R6: a load that coincides with the rollover goes straight to the active register.
    assert_active_direct_R6: assert property (@(posedge clk) disable iff (rst)
        (rollover_i && load_i) |=> (active_q == $past(val_i)));

endmodule

// File: rtl/pwm_glitchfree.sv
module pwm_glitchfree #(
    parameter int unsigned WIDTH = pwm_pkg::PWM_WIDTH_DEFAULT,
    parameter int unsigned DIV   = pwm_pkg::PWM_DIV_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] duty_val,
    input  logic             duty_load,
    output logic             pwm_out
);

    logic             tick;
    logic             rollover;
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] active;

    pwm_tick_gen #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pwm_count #(.WIDTH(WIDTH)) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .cnt_o      (cnt),
        .rollover_o (rollover)
    );

    pwm_duty_buf #(.WIDTH(WIDTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .load_i     (duty_load),
        .val_i      (duty_val),
        .rollover_i (rollover),
        .active_o   (active)
    );

    assign pwm_out = (active > cnt);

    // R7: a zero duty never drives the output high.
    assert_zero_low_R7: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |-> !pwm_out);
    // R8: one clock after reset the output is low and the counter is back at zero.
    assert_reset_low_R8: assert property (@(posedge clk)
        rst |=> (!pwm_out && cnt == '0));

endmodule

// File: tb/tb_pwm_glitchfree.sv
module tb_pwm_glitchfree;

    localparam int W      = 4;
    localparam int D      = 2;
    localparam int SUB    = 1 << D;
    localparam int PERIOD = (1 << W) * SUB;
    localparam logic [W-1:0] JUNK = 4'hA;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] duty_val = '0;
    logic         duty_load = 1'b0;
    logic         pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_glitchfree #(.WIDTH(W), .DIV(D)) dut (
        .clk       (clk),
        .rst       (rst),
        .duty_val  (duty_val),
        .duty_load (duty_load),
        .pwm_out   (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset for a few cycles, check the output, then release on a falling edge.
    task automatic do_reset();
        rst = 1'b1;
        duty_load = 1'b0;
        duty_val = JUNK;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R8 output low in reset", pwm_out, 0);
        rst = 1'b0;
    endtask

    // Watch n states from the start of a period and expect exp_duty*SUB leading high states.
    // A load is driven from index upd_at for upd_len cycles; the last one uses v_last.
    task automatic run_span(input int n, input int exp_duty, input int upd_at, input int upd_len,
                            input logic [W-1:0] v_early, input logic [W-1:0] v_last,
                            input string req);
        int high = 0;
        int first_bad = -1;
        int bad_val = 0;
        for (int i = 0; i < n; i++) begin
            logic exp_bit;
            exp_bit = (i < exp_duty * SUB);
            if (pwm_out) high++;
            if (pwm_out !== exp_bit && first_bad < 0) begin
                first_bad = i;
                bad_val = pwm_out;
            end
            if (upd_at >= 0 && i >= upd_at && i < upd_at + upd_len) begin
                duty_load = 1'b1;
                duty_val = (i == upd_at + upd_len - 1) ? v_last : v_early;
            end else begin
                duty_load = 1'b0;
                duty_val = JUNK;
            end
            @(negedge clk);
        end
        duty_load = 1'b0;
        check(first_bad < 0, {req, " shape (first bad index)"}, first_bad, -1);
        if (first_bad >= 0)
            $display("  index %0d: output %0d", first_bad, bad_val);
        check(high == ((exp_duty * SUB < n) ? exp_duty * SUB : n),
              {req, " high clocks"}, high, (exp_duty * SUB < n) ? exp_duty * SUB : n);
    endtask

    task automatic t_reset_and_midload();
        do_reset();
        // R5, R8: duty starts at 0; a mid-period load of 5 must not show yet.
        run_span(PERIOD, 0, 10, 1, 4'd5, 4'd5, "R5/R8 first period");
    endtask

    task automatic t_applied_then_edge_load();
        // R2, R1: duty 5 gives 5*SUB high clocks.
        run_span(PERIOD, 5, -1, 0, '0, '0, "R2 duty 5");
        // R6: load on the last state, which is the rollover tick cycle.
        run_span(PERIOD, 5, PERIOD - 1, 1, 4'd9, 4'd9, "R6 load at rollover");
        run_span(PERIOD, 9, 0, 1, 4'd15, 4'd15, "R6 value applied directly");
    endtask

    task automatic t_max_and_held_load();
        // R7 max duty; R4 held strobe, last value 7 wins.
        run_span(PERIOD, 15, 20, 2, 4'd3, 4'd7, "R7 max duty");
        run_span(PERIOD, 7, -1, 0, '0, '0, "R4 held load last value");
    endtask

    task automatic t_ignored_value_and_zero();
        // R3: junk value with no strobe throughout the previous period was ignored.
        run_span(PERIOD, 7, 30, 1, 4'd0, 4'd0, "R3 value ignored without strobe");
        run_span(PERIOD, 0, -1, 0, '0, '0, "R7 zero duty");
    endtask

    task automatic t_reset_mid_period();
        run_span(PERIOD, 0, 5, 1, 4'd11, 4'd11, "R5 load 11");
        // Load 6 into the shadow, then reset partway through the period.
        run_span(20, 11, 3, 1, 4'd6, 4'd6, "R2 partial period duty 11");
        do_reset();
        run_span(PERIOD, 0, -1, 0, '0, '0, "R8 active cleared");
        run_span(PERIOD, 0, -1, 0, '0, '0, "R8 shadow cleared");
    endtask

    initial begin
        @(negedge clk);
        t_reset_and_midload();
        t_applied_then_edge_load();
        t_max_and_held_load();
        t_ignored_value_and_zero();
        t_reset_mid_period();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule